// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block is a byte-wide asynchronous serial transmitter and receiver driven through a small register file. Software picks the character format in a mode register: 7 or 8 data bits, no, even or odd parity, and one or two stop bits. It sets the line speed through an 8-bit divisor. It turns the transmitter, the receiver and each interrupt source on or off in a control register. Outgoing bytes go through a one-deep transmit holding register into a shift register. Incoming bytes land in a receive data register.

The status register carries six flags. Hardware only ever sets a flag. Software clears a flag by writing 0 to its bit, and writing 1 to a bit leaves that bit unchanged. Flow control in both directions runs through these flags, not through a valid/ready pair.

On the transmit side, software writes the holding register and then clears the transmit-empty flag to hand the byte over. Hardware sets the flag again when it moves the byte into the shifter.

On the receive side, hardware raises receive-full when a good byte arrives. Software must clear receive-full before the next byte completes, or that next byte is lost as an overrun.

Four level interrupt outputs report:
- a received byte;
- a receive error;
- an empty holding register;
- the end of transmission.

Register reads are combinational and have no side effects.

Top module: `async_serial_port`

## Requirements
- R1: After reset, the status register reads 0x84 (transmit-empty bit 7 and transmit-end bit 2 set). The control and mode registers read 0x00, the divisor reads 0xFF, txd is high and all four interrupt outputs are low. The register addresses are: mode 0, divisor 1, control 2, status 3, transmit data 4, receive data 5.
- R2: With divisor value N, every bit on the line lasts (N+1)*32 clock cycles: 16 samples per bit on a clock divided by two.
- R3: A transmitted frame has these fields, in order:
  - a low start bit;
  - the data bits, LSB first: 7 when mode bit 6 is set, 8 otherwise;
  - a parity bit when mode bit 5 is set: even parity when mode bit 4 is clear, odd parity when it is set;
  - one high stop bit, or two when mode bit 3 is set.
- R4: Writing 0 to status bit 7 while control bit 5 (transmit enable) is set starts a transfer of the transmit data register.
  - Hardware sets bit 7 again when the byte enters the shifter.
  - Clearing bit 7 also clears status bit 2.
  - Status bit 2 sets when a frame ends and bit 7 is set.
- R5: Rewriting the transmit data register while a frame is on the line does not change that frame. The last value written before the shifter frees up is the one sent next, back to back.
- R6: With control bit 4 (receive enable) set, a frame with a valid stop bit and valid parity stores its data in the receive data register and sets status bit 6. In 7-bit mode, data bit 7 reads 0.
- R7: A frame that completes while status bit 6 is set sets status bit 5 (overrun) and leaves the receive data register unchanged.
- R8: A low stop bit sets status bit 4 (framing). It does not set bit 6 and does not update the receive data register. The receiver waits for the line to return high before it looks for a new start bit.
- R9: A parity mismatch sets status bit 3. It does not set bit 6 and does not update the receive data register.
- R10: Writing 0 to a status bit clears it. Writing 1 to a status bit leaves it unchanged.
- R11: The interrupt outputs are:
  - irq_tx_empty: control bit 7 and status bit 7;
  - irq_rx: control bit 6 and status bit 6;
  - irq_rx_err: control bit 6 and any of status bits 5:3;
  - irq_tx_end: control bit 2 and status bit 2.
- R12: With control bit 5 clear, txd stays high and a pending byte stays pending. With control bit 4 clear, no frame is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Received-byte interrupt |
| irq_rx_err | output | 1 | Receive-error interrupt |
| irq_tx_empty | output | 1 | Holding-register-empty interrupt |
| irq_tx_end | output | 1 | Transmission-end interrupt |

## Verification
The bench builds the block with its default parameters: a prescale of 2 and 16 samples per bit. It programs divisor values 0 and 2, which give 32-clock and 96-clock bits. At these speeds, back-to-back frames, overruns, framing and parity faults and mode changes all fit into a few thousand cycles. The larger divisor shows that the bit time scales with N+1 and not merely with a constant.

// File: rtl/asp_pkg.sv
package asp_pkg;

  // Register addresses.
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_DIV  = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_TXD  = 3'd4;
  localparam logic [2:0] A_RXD  = 3'd5;

  // Mode bits.
  localparam int M_SEVEN = 6;
  localparam int M_PAREN = 5;
  localparam int M_PODD  = 4;
  localparam int M_STOP2 = 3;

  // Control bits.
  localparam int C_TXEIE = 7;
  localparam int C_RXIE  = 6;
  localparam int C_TXEN  = 5;
  localparam int C_RXEN  = 4;
  localparam int C_ENDIE = 2;

  // Status bits.
  localparam int S_TXE  = 7;
  localparam int S_RXF  = 6;
  localparam int S_OVR  = 5;
  localparam int S_FRM  = 4;
  localparam int S_PAR  = 3;
  localparam int S_TEND = 2;

  typedef struct packed {
    logic seven;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } line_cfg_t;

  typedef struct packed {
    logic [11:0] bits;  // bits[0] goes on the line first
    logic [3:0]  len;   // number of bit periods in the frame
  } frame_t;

  function automatic frame_t build_frame(input logic [7:0] d, input line_cfg_t c);
    frame_t f;
    logic [7:0] m;
    logic p;
    m = d;
    if (c.seven) m[7] = 1'b0;
    p = (^m) ^ c.par_odd;
    f.bits = '1;
    f.bits[0] = 1'b0;
    f.bits[8:1] = m;
    if (c.seven) f.bits[8] = 1'b1;
    if (c.par_en) begin
      if (c.seven) f.bits[8] = p;
      else         f.bits[9] = p;
    end
    f.len = 4'd10 - {3'b0, c.seven} + {3'b0, c.par_en} + {3'b0, c.two_stop};
    return f;
  endfunction

endpackage

// File: rtl/asp_baud_gen.sv
module asp_baud_gen #(
  parameter int DIV_W    = 8,
  parameter int PRESCALE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam int CNT_W = DIV_W + $clog2(PRESCALE) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = (CNT_W'(divisor) + CNT_W'(1)) * CNT_W'(PRESCALE) - CNT_W'(1);
  assign tick  = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      en,
  input  logic      pend,
  input  logic [7:0] data,
  input  line_cfg_t cfg,
  output logic      txd,
  output logic      take,
  output logic      done
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  logic             busy_q;
  logic [SUB_W-1:0] sub_q;
  logic [3:0]       left_q;
  logic [11:0]      sh_q;
  logic             frame_end;
  logic             load;
  frame_t           fr;

  assign fr        = build_frame(data, cfg);
  assign frame_end = busy_q && tick && (sub_q == SUB_LAST) && (left_q == 4'd1);
  assign load      = en && tick && pend && (!busy_q || frame_end);
  assign take      = load;
  assign done      = en && frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      txd    <= 1'b1;
      sub_q  <= '0;
      left_q <= '0;
      sh_q   <= '1;
    end else if (!en) begin
      busy_q <= 1'b0;
      txd    <= 1'b1;
      sub_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      txd    <= fr.bits[0];
      sh_q   <= {1'b1, fr.bits[11:1]};
      left_q <= fr.len;
      sub_q  <= '0;
    end else if (busy_q && tick) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        if (left_q == 4'd1) begin
          busy_q <= 1'b0;
          txd    <= 1'b1;
        end else begin
          left_q <= left_q - 4'd1;
          txd    <= sh_q[0];
          sh_q   <= {1'b1, sh_q[11:1]};
        end
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       rxd,
  input  line_cfg_t  cfg,
  output logic       done,
  output logic [7:0] data,
  output logic       perr,
  output logic       ferr
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVERSAMPLE / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_state_t;

  rx_state_t        st_q;
  logic [1:0]       sync_q;
  logic             rx_s;
  logic [SUB_W-1:0] sub_q;
  logic [3:0]       idx_q;
  logic [9:0]       sh_q;
  logic             fin_q;
  logic [3:0]       need;
  logic             pbit;
  logic             stop_bit;

  assign rx_s = sync_q[1];
  assign need = 4'd9 - {3'b0, cfg.seven} + {3'b0, cfg.par_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      fin_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      fin_q  <= 1'b0;
      if (!en) begin
        st_q <= RX_IDLE;
      end else begin
        case (st_q)
          RX_IDLE: if (tick && !rx_s) begin
            st_q  <= RX_START;
            sub_q <= '0;
          end
          RX_START: if (tick) begin
            if (sub_q == SUB_MID) begin
              sub_q <= '0;
              idx_q <= '0;
              st_q  <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
              sub_q <= sub_q + SUB_W'(1);
            end
          end
          RX_BITS: if (tick) begin
            if (sub_q == SUB_LAST) begin
              sub_q       <= '0;
              sh_q[idx_q] <= rx_s;
              if (idx_q == need - 4'd1) begin
                fin_q <= 1'b1;
                st_q  <= RX_HOLD;
              end else begin
                idx_q <= idx_q + 4'd1;
              end
            end else begin
              sub_q <= sub_q + SUB_W'(1);
            end
          end
          default: if (rx_s) st_q <= RX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    data = cfg.seven ? {1'b0, sh_q[6:0]} : sh_q[7:0];
    pbit = cfg.seven ? sh_q[7] : sh_q[8];
    case ({cfg.seven, cfg.par_en})
      2'b00:   stop_bit = sh_q[8];
      2'b01:   stop_bit = sh_q[9];
      2'b10:   stop_bit = sh_q[7];
      default: stop_bit = sh_q[8];
    endcase
  end

  assign done = fin_q;
  assign perr = cfg.par_en && ((^data ^ pbit) != cfg.par_odd);
  assign ferr = !stop_bit;
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import asp_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int PRESCALE   = 2,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq_rx,
  output logic       irq_rx_err,
  output logic       irq_tx_empty,
  output logic       irq_tx_end
);
  logic [7:0]       mode_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       ctrl_q;
  logic [7:0]       tdr_q;
  logic [7:0]       rdr_q;
  logic st_txe, st_rxf, st_ovr, st_frm, st_par, st_tend;

  line_cfg_t  cfg;
  logic       tick;
  logic       tx_take, tx_done;
  logic       rx_done, rx_perr, rx_ferr;
  logic [7:0] rx_data;
  logic       te_en, re_en;
  logic       wr_st;
  logic [7:0] clr;
  logic       rx_good;

  assign cfg   = '{seven: mode_q[M_SEVEN], par_en: mode_q[M_PAREN],
                   par_odd: mode_q[M_PODD], two_stop: mode_q[M_STOP2]};
  assign te_en = ctrl_q[C_TXEN];
  assign re_en = ctrl_q[C_RXEN];

  asp_baud_gen #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(div_q), .tick(tick));

  asp_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(te_en), .pend(!st_txe),
    .data(tdr_q), .cfg(cfg), .txd(txd), .take(tx_take), .done(tx_done));

  asp_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(re_en), .rxd(rxd), .cfg(cfg),
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '1;
      ctrl_q <= '0;
      tdr_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MODE:  mode_q <= reg_wdata;
        A_DIV:   div_q  <= DIV_W'(reg_wdata);
        A_CTRL:  ctrl_q <= reg_wdata;
        A_TXD:   tdr_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Status: hardware sets, a written 0 clears.
  assign wr_st   = reg_wr && (reg_addr == A_STAT);
  assign clr     = wr_st ? ~reg_wdata : 8'h00;
  assign rx_good = rx_done && !st_rxf && !rx_ferr && !rx_perr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_txe  <= 1'b1;
      st_tend <= 1'b1;
      st_rxf  <= 1'b0;
      st_ovr  <= 1'b0;
      st_frm  <= 1'b0;
      st_par  <= 1'b0;
      rdr_q   <= '0;
    end else begin
      if (tx_take)         st_txe <= 1'b1;
      else if (clr[S_TXE]) st_txe <= 1'b0;

      if (tx_done && st_txe)                 st_tend <= 1'b1;
      else if (clr[S_TEND] || clr[S_TXE])    st_tend <= 1'b0;

      if (rx_good)         st_rxf <= 1'b1;
      else if (clr[S_RXF]) st_rxf <= 1'b0;

      if (rx_done && st_rxf) st_ovr <= 1'b1;
      else if (clr[S_OVR])   st_ovr <= 1'b0;

      if (rx_done && !st_rxf && rx_ferr) st_frm <= 1'b1;
      else if (clr[S_FRM])               st_frm <= 1'b0;

      if (rx_done && !st_rxf && rx_perr) st_par <= 1'b1;
      else if (clr[S_PAR])               st_par <= 1'b0;

      if (rx_good) rdr_q <= rx_data;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_DIV:   reg_rdata = 8'(div_q);
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {st_txe, st_rxf, st_ovr, st_frm, st_par, st_tend, 2'b00};
      A_TXD:   reg_rdata = tdr_q;
      A_RXD:   reg_rdata = rdr_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq_tx_empty = ctrl_q[C_TXEIE] && st_txe;
  assign irq_rx       = ctrl_q[C_RXIE] && st_rxf;
  assign irq_rx_err   = ctrl_q[C_RXIE] && (st_ovr || st_frm || st_par);
  assign irq_tx_end   = ctrl_q[C_ENDIE] && st_tend;
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       te,
  input logic       re,
  input logic       txe,
  input logic       tend,
  input logic       rxf,
  input logic       ovr,
  input logic [7:0] rdr
);
  // R12: a disabled transmitter holds the line idle.
  p_line_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !te |=> txd);

  // R12: receive-full only rises while the receiver is enabled.
  p_rx_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxf) |-> $past(re));

  // R7: overrun needs an unread byte, and that byte is kept.
  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rxf));

  p_ovr_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(rdr));

  // R4: transmit-end only appears with an empty holding register.
  p_tend_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> txe);
endmodule

bind async_serial_port asp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .te(te_en), .re(re_en),
  .txe(st_txe), .tend(st_tend), .rxf(st_rxf), .ovr(st_ovr), .rdr(rdr_q));

// File: tb/async_serial_port_tb.sv
`timescale 1ns/1ps
module async_serial_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rxd = 1'b1;
  logic       txd, irq_rx, irq_rx_err, irq_tx_empty, irq_tx_end;

  int  total = 0;
  int  bad = 0;
  real bit_ns = 160.0;

  always #2.5 clk = ~clk;

  async_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd),
    .irq_rx(irq_rx), .irq_rx_err(irq_rx_err), .irq_tx_empty(irq_tx_empty),
    .irq_tx_end(irq_tx_end));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_div(input logic [7:0] n);
    wr(3'd1, n);
    bit_ns = (n + 1) * 32 * 5.0;
  endtask

  task automatic wait_txe();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(3'd3, s);
      if (s[7]) break;
    end
  endtask

  // Decode one frame from txd.
  task automatic get_frame(input int dl, input bit pen, input int nstop,
                           output logic [7:0] d, output logic p,
                           output bit stops_ok, output realtime t0);
    d = 8'h00; p = 1'b0; stops_ok = 1'b1;
    wait (txd === 1'b0);
    t0 = $realtime;
    #(bit_ns / 2);
    if (txd !== 1'b0) stops_ok = 1'b0;
    for (int i = 0; i < dl; i++) begin
      #(bit_ns);
      d[i] = txd;
    end
    if (pen) begin
      #(bit_ns);
      p = txd;
    end
    for (int i = 0; i < nstop; i++) begin
      #(bit_ns);
      if (txd !== 1'b1) stops_ok = 1'b0;
    end
  endtask

  // Drive one frame onto rxd.
  task automatic send_rx(input logic [7:0] d, input int dl, input bit pen,
                         input bit podd, input bit flip, input bit stopv);
    logic [7:0] m;
    m = (dl == 7) ? {1'b0, d[6:0]} : d;
    rxd = 1'b0;
    #(bit_ns);
    for (int i = 0; i < dl; i++) begin
      rxd = m[i];
      #(bit_ns);
    end
    if (pen) begin
      rxd = (^m) ^ podd ^ flip;
      #(bit_ns);
    end
    rxd = stopv;
    #(bit_ns);
    rxd = 1'b1;
    #(bit_ns);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd3, v); chk("R1 status", v, 8'h84);
    rd(3'd2, v); chk("R1 control", v, 8'h00);
    rd(3'd0, v); chk("R1 mode", v, 8'h00);
    rd(3'd1, v); chk("R1 divisor", v, 8'hFF);
    chk("R1 txd", txd, 1'b1);
    chk("R1 irqs", {irq_rx, irq_rx_err, irq_tx_empty, irq_tx_end}, 4'b0000);
  endtask

  task automatic t_irq_tx();
    logic [7:0] v;
    wr(3'd2, 8'h84);
    #1 chk("R11 irq_tx_empty", irq_tx_empty, 1'b1);
    chk("R11 irq_tx_end", irq_tx_end, 1'b1);
    wr(3'd3, 8'hFB);
    #1 chk("R11 irq_tx_end cleared", irq_tx_end, 1'b0);
    rd(3'd3, v); chk("R10 clear tend only", v, 8'h80);
    wr(3'd3, 8'hFF);
    rd(3'd3, v); chk("R10 ones do not set", v, 8'h80);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_tx_8n1();
    logic [7:0] d, v; logic p; bit ok; realtime t0;
    set_div(8'd0); wr(3'd0, 8'h00); wr(3'd2, 8'h20);
    wr(3'd4, 8'hA5); wr(3'd3, 8'h7F);
    get_frame(8, 1'b0, 1, d, p, ok, t0);
    chk("R3 8N1 data", d, 8'hA5);
    chk("R3 8N1 framing", ok, 1'b1);
    rd(3'd3, v);
    chk("R4 txe set after load", v[7], 1'b1);
    chk("R4 tend clear while busy", v[2], 1'b0);
    #(bit_ns);
    rd(3'd3, v); chk("R4 tend after frame", v[2], 1'b1);
  endtask

  task automatic t_bit_time();
    realtime a, b;
    set_div(8'd2); wr(3'd0, 8'h00); wr(3'd2, 8'h20);
    wr(3'd4, 8'h00); wr(3'd3, 8'h7F);
    wait (txd === 1'b0); a = $realtime;
    wait (txd === 1'b1); b = $realtime;
    chk("R2 nine low bits ns", int'(b - a), 9 * 96 * 5);
    #(2 * bit_ns);
    set_div(8'd0);
  endtask

  task automatic t_tx_7o2();
    logic [7:0] d1, d2; logic p1, p2; bit ok1, ok2; realtime t1, t2;
    wr(3'd0, 8'h78); wr(3'd2, 8'h20);
    wr(3'd4, 8'h35); wr(3'd3, 8'h7F);
    fork
      begin
        get_frame(7, 1'b1, 2, d1, p1, ok1, t1);
        get_frame(7, 1'b1, 2, d2, p2, ok2, t2);
      end
      begin
        wait_txe();
        wr(3'd4, 8'h12); wr(3'd3, 8'h7F);
        wr(3'd4, 8'h4C);
      end
    join
    chk("R5 frame in flight unchanged", d1, 8'h35);
    chk("R3 odd parity", p1, ~^8'h35);
    chk("R3 two stops", ok1 && ok2, 1'b1);
    chk("R5 last write sent next", d2, 8'h4C);
    chk("R3 frame length 11 bits", int'(t2 - t1), int'(11 * bit_ns));
    #(bit_ns);
  endtask

  task automatic t_te_off();
    logic [7:0] d, v; logic p; bit ok; realtime t0; bit hi;
    wr(3'd0, 8'h00); wr(3'd2, 8'h00);
    wr(3'd4, 8'h81); wr(3'd3, 8'h7F);
    hi = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #(bit_ns);
      if (txd !== 1'b1) hi = 1'b0;
    end
    chk("R12 txd idle when disabled", hi, 1'b1);
    rd(3'd3, v); chk("R12 byte stays pending", v[7], 1'b0);
    wr(3'd2, 8'h20);
    get_frame(8, 1'b0, 1, d, p, ok, t0);
    chk("R12 pending byte sent on enable", d, 8'h81);
    #(bit_ns);
  endtask

  task automatic t_rx_ok();
    logic [7:0] v;
    wr(3'd0, 8'h00); wr(3'd2, 8'h50);
    send_rx(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    rd(3'd3, v); chk("R6 rx full", v[6], 1'b1);
    rd(3'd5, v); chk("R6 rx data", v, 8'h3C);
    chk("R11 irq_rx", {irq_rx, irq_rx_err}, 2'b10);
    wr(3'd3, 8'hBF);
    rd(3'd3, v); chk("R10 rx full cleared", v[6], 1'b0);
    chk("R11 irq_rx drops", irq_rx, 1'b0);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    send_rx(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    send_rx(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    rd(3'd3, v); chk("R7 overrun flag", v[5], 1'b1);
    rd(3'd5, v); chk("R7 first byte kept", v, 8'h11);
    chk("R11 irq_rx_err", irq_rx_err, 1'b1);
    wr(3'd3, 8'h87);
    rd(3'd3, v); chk("R10 errors cleared", v & 8'h78, 8'h00);
  endtask

  task automatic t_framing();
    logic [7:0] v;
    send_rx(8'h55, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(3'd3, v); chk("R8 framing flag, no rx full", v & 8'h50, 8'h10);
    rd(3'd5, v); chk("R8 data not stored", v, 8'h11);
    wr(3'd3, 8'h87);
    send_rx(8'h66, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    rd(3'd5, v); chk("R8 clean frame after fault", v, 8'h66);
    wr(3'd3, 8'h87);
  endtask

  task automatic t_parity();
    logic [7:0] v;
    wr(3'd0, 8'h20);
    send_rx(8'h07, 8, 1'b1, 1'b0, 1'b1, 1'b1);
    rd(3'd3, v); chk("R9 parity flag, no rx full", v & 8'h48, 8'h08);
    wr(3'd3, 8'h87);
    wr(3'd0, 8'h70);
    send_rx(8'hAA, 7, 1'b1, 1'b1, 1'b0, 1'b1);
    rd(3'd3, v); chk("R9 good odd parity", v & 8'h48, 8'h40);
    rd(3'd5, v); chk("R6 seven-bit data", v, 8'h2A);
    wr(3'd3, 8'h87);
  endtask

  task automatic t_re_off();
    logic [7:0] v;
    wr(3'd0, 8'h00); wr(3'd2, 8'h40);
    send_rx(8'h99, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    rd(3'd3, v); chk("R12 no rx when disabled", v[6], 1'b0);
    rd(3'd5, v); chk("R12 rx data untouched", v, 8'h2A);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_irq_tx();
    t_tx_8n1();
    t_bit_time();
    t_tx_7o2();
    t_te_off();
    t_rx_ok();
    t_overrun();
    t_framing();
    t_parity();
    t_re_off();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule